// File: doc/BRIEF.md
# Nine-bit FIFO controller with read rewind

This block buffers 9-bit words between a producer and a consumer that share one sampling clock. Storage is a dual-port array of `DEPTH` words. A write strobe stores the word on the input bus. A read strobe returns the oldest stored word on the registered output bus in the cycle after the strobe is sampled. The ninth bit is carried through unchanged, so it can hold parity or a control mark. Three active-low flags report the fill level: empty, full, and more-than-half-full.

An active-low rewind input moves only the read pointer back to location zero. The words written since reset can then be read out again. This works as long as no more than `DEPTH` writes have happened since reset. The write pointer is left alone, and all flags follow from the new pointer distance. A small control machine has two states. In `CTL_RUN` the strobes are accepted normally. The transition *rewind-request* goes from `CTL_RUN` to `CTL_REWIND`. It is taken when rewind is sampled low while both strobes are idle, and it clears the read pointer on that edge. In `CTL_REWIND` every strobe is dropped. The transition *rewind-release* goes back to `CTL_RUN` on the edge that samples rewind high, and that edge also drops strobes. The asynchronous active-low reset clears both pointers and returns the machine to `CTL_RUN`.

`DEPTH` defaults to 1024 and may be any power of two of 4 or more. A setting of 65536 is allowed.

Top module: `fifo_rtx_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, both pointers sit at location zero. `empty_n` is 0, `full_n` is 1, `half_n` is 1, and `rd_data` is 0.
- R2: Words leave in the order they were accepted, with all 9 bits unchanged. An accepted read shows its word on `rd_data` after the rising edge that sampled the strobe, and `rd_data` holds that word until the next accepted read.
- R3: A write strobe sampled while `full_n` is 0 is ignored. The word is never stored and the write pointer does not move.
- R4: `empty_n` is 0 exactly when the stored count is zero. A read strobe sampled while `empty_n` is 0 is ignored: `rd_data` keeps its value and the read pointer does not move.
- R5: `full_n` is 0 exactly when the stored count equals `DEPTH`. With no reads after reset, this happens on the `DEPTH`-th write.
- R6: `half_n` is 0 exactly when the stored count exceeds `DEPTH/2`. It falls on the write that takes the count to `DEPTH/2+1` and rises on the read that brings the count back to `DEPTH/2`.
- R7: A read and a write sampled in the same cycle, while the block is neither empty nor full, are both accepted. Both pointers move and the count is unchanged.
- R8: In `CTL_RUN`, `rewind_n` sampled low with both strobes idle sets the read pointer to zero and leaves the write pointer unchanged. The flags are then recomputed from the write pointer alone.
- R9: In `CTL_RUN`, `rewind_n` sampled low while either strobe is high is ignored, and the strobes are handled normally.
- R10: Strobes sampled in `CTL_REWIND` are dropped. This includes the edge that samples `rewind_n` high and returns to `CTL_RUN`. Normal operation resumes on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for strobes and state |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | Write strobe, active high |
| wr_data | input | 9 | Word to store |
| rd_stb | input | 1 | Read strobe, active high |
| rd_data | output | 9 | Registered word returned by the last accepted read |
| rewind_n | input | 1 | Read-pointer rewind request, active low |
| empty_n | output | 1 | Low when nothing is stored |
| full_n | output | 1 | Low when `DEPTH` words are stored |
| half_n | output | 1 | Low when more than `DEPTH/2` words are stored |

## Verification
A pointer that slips by one shows up at the data port on the very next accepted read, as a repeated, skipped or stale word. The bench therefore compares every returned word against a scoreboard, including across pointer wrap and after a rewind. A wrong count or a wrong flag threshold shows up on the flag pins in the same cycle as the write or read that crosses a boundary, so the flags are compared after every edge. A control machine stuck in or out of the rewind state shows up within one or two edges: strobes are either dropped when they should be accepted, or accepted when they should be dropped. The bench then sees a count mismatch on the flags, followed by wrong read data.

// File: rtl/fifo_rtx_pkg.sv
package fifo_rtx_pkg;

    typedef enum logic [0:0] {
        CTL_RUN    = 1'b0,
        CTL_REWIND = 1'b1
    } ctl_state_t;

    localparam int unsigned WORD_W = 9;

endpackage

// File: rtl/fifo_rtx_ctl.sv
module fifo_rtx_ctl
    import fifo_rtx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic       rd_stb,
    input  logic       rewind_n,
    input  logic       empty_n,
    input  logic       full_n,
    output logic       do_wr,
    output logic       do_rd,
    output logic       do_rewind,
    output ctl_state_t state
);

    ctl_state_t state_q;
    ctl_state_t state_d;
    logic       rewind_req;

    // A rewind is only honoured when both strobes are idle.
    assign rewind_req = !rewind_n && !wr_stb && !rd_stb;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CTL_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_RUN:    if (rewind_req) state_d = CTL_REWIND;
            CTL_REWIND: if (rewind_n)   state_d = CTL_RUN;
            default:    state_d = CTL_RUN;
        endcase
    end

    // Outputs per state
    always_comb begin
        do_wr     = 1'b0;
        do_rd     = 1'b0;
        do_rewind = 1'b0;
        unique case (state_q)
            CTL_RUN: begin
                do_rewind = rewind_req;
                do_wr     = wr_stb && full_n;
                do_rd     = rd_stb && empty_n;
            end
            CTL_REWIND: begin
                do_wr = 1'b0;
                do_rd = 1'b0;
            end
            default: begin
                do_wr = 1'b0;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/fifo_rtx_ptrs.sv
module fifo_rtx_ptrs #(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_wr,
    input  logic          do_rd,
    input  logic          do_rewind,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [PW-1:0] count
);

    // Write pointer carries one wrap bit above the address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (do_wr) begin
            wr_ptr <= wr_ptr + PW'(1);
        end
    end

    // Read pointer: rewind has priority (strobes are idle when it fires).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (do_rewind) begin
            rd_ptr <= '0;
        end else if (do_rd) begin
            rd_ptr <= rd_ptr + PW'(1);
        end
    end

    assign count = wr_ptr - rd_ptr;

endmodule

// File: rtl/fifo_rtx_flags.sv
module fifo_rtx_flags #(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = AW + 1,
    localparam int unsigned HALF = DEPTH / 2
) (
    input  logic [PW-1:0] count,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_n
);

    always_comb begin
        empty_n = (count != '0);
        full_n  = (count != PW'(DEPTH));
        half_n  = !(count > PW'(HALF));
    end

endmodule

// File: rtl/fifo_rtx_store.sv
module fifo_rtx_store #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned W     = 9,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/fifo_rtx_ctrl.sv
module fifo_rtx_ctrl
    import fifo_rtx_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic [WORD_W-1:0] rd_data,
    input  logic              rewind_n,
    output logic              empty_n,
    output logic              full_n,
    output logic              half_n
);

    logic          do_wr;
    logic          do_rd;
    logic          do_rewind;
    ctl_state_t    state;
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] count;

    fifo_rtx_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .rewind_n  (rewind_n),
        .empty_n   (empty_n),
        .full_n    (full_n),
        .do_wr     (do_wr),
        .do_rd     (do_rd),
        .do_rewind (do_rewind),
        .state     (state)
    );

    fifo_rtx_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_wr     (do_wr),
        .do_rd     (do_rd),
        .do_rewind (do_rewind),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .count     (count)
    );

    fifo_rtx_flags #(.DEPTH(DEPTH)) u_flags (
        .count   (count),
        .empty_n (empty_n),
        .full_n  (full_n),
        .half_n  (half_n)
    );

    fifo_rtx_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (do_wr),
        .waddr (wr_ptr[AW-1:0]),
        .wdata (wr_data),
        .re    (do_rd),
        .raddr (rd_ptr[AW-1:0]),
        .rdata (rd_data)
    );

    // R3
    wr_block_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |=> $stable(wr_ptr));

    // R4
    rd_block_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && rewind_n) |=> $stable(rd_ptr));

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= PW'(DEPTH));

    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !rd_stb && rewind_n) |=> !full_n);

    // R7
    both_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CTL_RUN && wr_stb && rd_stb && empty_n && full_n)
        |=> $stable(count));

    // R8
    rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CTL_RUN && !rewind_n && !wr_stb && !rd_stb)
        |=> (rd_ptr == '0 && $stable(wr_ptr)));

    // R10
    rewind_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CTL_REWIND) |=> ($stable(wr_ptr) && $stable(rd_data)));

endmodule

// File: tb/fifo_rtx_ctrl_tb_top.sv
module fifo_rtx_ctrl_tb_top;

    localparam int DEPTH = 16;
    localparam int HALF  = DEPTH / 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_stb;
    logic [8:0] wr_data;
    logic       rd_stb;
    logic [8:0] rd_data;
    logic       rewind_n;
    logic       empty_n;
    logic       full_n;
    logic       half_n;

    always #4 clk = ~clk;

    fifo_rtx_ctrl #(.DEPTH(DEPTH)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .rd_stb   (rd_stb),
        .rd_data  (rd_data),
        .rewind_n (rewind_n),
        .empty_n  (empty_n),
        .full_n   (full_n),
        .half_n   (half_n)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // Scoreboard model
    logic [8:0] hist [DEPTH];
    int         wr_idx;
    int         rd_idx;
    bit         m_rew;
    logic [8:0] exp_q [$];

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Driver: called at a falling edge, returns at the next falling edge.
    task automatic step(input bit w, input logic [8:0] d, input bit r, input bit rew);
        int cnt;
        bit aw;
        bit ar;
        wr_stb = w; wr_data = d; rd_stb = r; rewind_n = rew;
        cnt = wr_idx - rd_idx;
        if (m_rew) begin
            if (rew) m_rew = 1'b0;          // R10: dropped, including exit edge
        end else if (!rew && !w && !r) begin
            rd_idx = 0;                     // R8
            m_rew  = 1'b1;
        end else begin                      // R9: rewind ignored with strobes
            aw = w && (cnt < DEPTH);
            ar = r && (cnt > 0);
            if (ar) begin
                exp_q.push_back(hist[rd_idx % DEPTH]);
                rd_idx++;
            end
            if (aw) begin
                hist[wr_idx % DEPTH] = d;
                wr_idx++;
            end
        end
        @(posedge clk);
        #2;
        cnt = wr_idx - rd_idx;
        chk(empty_n == (cnt != 0),     "R4 empty_n", int'(empty_n), int'(cnt != 0));
        chk(full_n  == (cnt != DEPTH), "R5 full_n",  int'(full_n),  int'(cnt != DEPTH));
        chk(half_n  == !(cnt > HALF),  "R6 half_n",  int'(half_n),  int'(!(cnt > HALF)));
        @(negedge clk);
    endtask

    // Monitor: compares each returned word with the scoreboard head.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (exp_q.size() > 0) begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R2 rd_data order", int'(rd_data), int'(e));
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0; rewind_n = 1'b1; wr_data = '0;
        wr_idx = 0; rd_idx = 0; m_rew = 1'b0; exp_q.delete();
        repeat (3) @(negedge clk);
        chk(empty_n == 1'b0 && full_n && half_n, "R1 flags in reset",
            {29'd0, empty_n, full_n, half_n}, 3);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [8:0] held;
        do_reset();
        chk(empty_n == 1'b0 && full_n == 1'b1 && half_n == 1'b1, "R1 flags after reset",
            {29'd0, empty_n, full_n, half_n}, 3);
        chk(rd_data == 9'h000, "R1 rd_data after reset", int'(rd_data), 0);

        // R2: ordering and ninth bit
        step(1, 9'h1A5, 0, 1);
        step(1, 9'h0FF, 0, 1);
        step(1, 9'h100, 0, 1);
        repeat (3) step(0, 9'h000, 1, 1);

        // R4: read on empty is ignored
        held = rd_data;
        step(0, 9'h000, 1, 1);
        chk(rd_data == held, "R4 rd_data held on empty read", int'(rd_data), int'(held));
        step(1, 9'h055, 0, 1);
        step(0, 9'h000, 1, 1);

        // Fill: R5 and R6 set points, with pointer wrap
        for (int i = 0; i < DEPTH; i++) begin
            step(1, 9'(9'h180 + i), 0, 1);
            if (i == HALF - 1) chk(half_n == 1'b1, "R6 half_n at DEPTH/2", int'(half_n), 1);
            if (i == HALF)     chk(half_n == 1'b0, "R6 half_n above DEPTH/2", int'(half_n), 0);
            if (i == DEPTH - 2) chk(full_n == 1'b1, "R5 full_n at DEPTH-1", int'(full_n), 1);
        end
        chk(full_n == 1'b0, "R5 full_n after DEPTH writes", int'(full_n), 0);

        // R3: write while full is ignored
        step(1, 9'h1EE, 0, 1);
        chk(full_n == 1'b0, "R3 full_n after ignored write", int'(full_n), 0);
        step(0, 9'h000, 1, 1);
        chk(full_n == 1'b1, "R5 full_n after one read", int'(full_n), 1);

        // R7: simultaneous read and write
        step(1, 9'h0AA, 1, 1);
        chk(full_n == 1'b1 && empty_n == 1'b1 && half_n == 1'b0, "R7 count unchanged",
            {29'd0, empty_n, full_n, half_n}, 6);

        // Drain: R6 clear point and order check (0x1EE must never appear)
        while (wr_idx - rd_idx > HALF + 1) step(0, 9'h000, 1, 1);
        chk(half_n == 1'b0, "R6 half_n at DEPTH/2+1", int'(half_n), 0);
        step(0, 9'h000, 1, 1);
        chk(half_n == 1'b1, "R6 half_n back at DEPTH/2", int'(half_n), 1);
        while (wr_idx - rd_idx > 0) step(0, 9'h000, 1, 1);
        chk(empty_n == 1'b0, "R4 empty after drain", int'(empty_n), 0);

        // R8: rewind replays from location zero
        do_reset();
        for (int i = 0; i < 5; i++) step(1, 9'(9'h0C0 + 7 * i), 0, 1);
        repeat (3) step(0, 9'h000, 1, 1);
        step(0, 9'h000, 0, 0);
        step(0, 9'h000, 0, 1);
        chk(empty_n == 1'b1 && half_n == 1'b1, "R8 flags after rewind",
            {30'd0, empty_n, half_n}, 3);
        repeat (5) step(0, 9'h000, 1, 1);
        chk(empty_n == 1'b0, "R8 empty after replay", int'(empty_n), 0);

        // R9: rewind ignored while a strobe is active
        step(1, 9'h111, 0, 1);
        step(1, 9'h122, 0, 1);
        step(0, 9'h000, 1, 0);
        chk(rd_data == 9'h111, "R9 read proceeds despite rewind", int'(rd_data), 9'h111);
        step(0, 9'h000, 1, 1);

        // R10: strobes dropped while rewinding
        step(0, 9'h000, 0, 0);
        held = rd_data;
        step(1, 9'h077, 1, 0);
        step(1, 9'h078, 1, 1);
        chk(rd_data == held, "R10 read dropped in rewind", int'(rd_data), int'(held));
        repeat (7) step(0, 9'h000, 1, 1);
        chk(empty_n == 1'b0, "R10 no extra words stored", int'(empty_n), 0);

        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule